// File: doc/BRIEF.md
# Video Controller CPU Register Interface

This block sits between a host CPU's byte-wide bus and a tile-based video controller. It holds the control and render-configuration bytes that the renderer consumes, the horizontal and vertical scroll offsets, and the pointer into video memory. The CPU reaches video memory and the 256-byte sprite attribute memory through data ports. The pointer into video memory advances automatically after every access, and reads from video memory pass through a one-byte holding buffer.

The renderer signals the start and end of vertical blank and reports sprite-zero overlaps. The block turns these into status flags and into a level NMI request. A second CPU-side strobe starts a page copy from system memory into sprite memory. The copy reads one byte and writes one byte per two-cycle step, and the CPU bus is held off until it ends.

CPU accesses use a one-cycle `cpu_sel` strobe. Read data is valid combinationally in that same cycle, and every side effect of the access, such as flag clears or pointer steps, takes effect at the following clock edge.

Top module: `vid_regif`

## Requirements
- R1: After reset, the control byte, the render-config byte, both scroll values and the video pointer are all zero. The write toggle selects the first write, `nmi` and `cpu_stall` are low, and a status read returns 0x00.
- R2: Register selects on `cpu_addr` are 0 control, 1 render-config, 2 status, 3 scroll, 4 video pointer, 5 video data, 6 sprite pointer and 7 sprite data. Writes to selects 0 and 1 appear on `ctrl_reg` and `render_cfg` one cycle later.
- R3: Each video-data access (read or write) advances the 14-bit video pointer after the access. The step is 1 when control bit 2 is 0 and 32 when it is 1, and the pointer wraps modulo 16384. A video-data write drives `vram_we` with `vram_addr` equal to the pointer before the step.
- R4: The first write to select 4 loads pointer bits 13:8 from `cpu_wdata` bits 5:0. The second write loads pointer bits 7:0.
- R5: The first write to select 3 sets the horizontal scroll and the second sets the vertical scroll. Selects 3 and 4 share one write toggle, so a pointer write that follows a single scroll write is taken as the low byte.
- R6: A status read returns {vblank flag, sprite-zero flag, 6'b0} in bits 7, 6 and 5:0. The read clears the vblank flag and returns the write toggle to the first write.
- R7: A `vblank_start` pulse sets the vblank flag, and this set wins over a status-read clear in the same cycle. A `vblank_end` pulse clears the flag. `nmi` is high exactly while the vblank flag is set and control bit 7 is 1.
- R8: An `obj0_hit` pulse sets the sprite-zero flag. A status read leaves the flag set, and a `vblank_end` pulse clears it.
- R9: A video-data read returns the buffered byte. The buffer then loads `vram_rdata` fetched at the pointer's pre-step address, so the first read after a pointer change returns the older byte. The buffer is zero after reset.
- R10: A sprite-data write stores at the 8-bit sprite pointer and a sprite-data read returns the byte there. Each such access advances the sprite pointer by one, wrapping modulo 256.
- R11: A `dma_go` pulse while idle takes the page from `cpu_wdata`. It copies system bytes page*256+i, for i from 0 to 255, into sprite memory at the sprite pointer plus i. `cpu_stall` stays high for exactly 512 cycles, CPU accesses are ignored during that time, and the sprite pointer ends where it began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | CPU access strobe, one cycle per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register select |
| cpu_wdata | input | 8 | CPU write data, also the copy page |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| cpu_stall | output | 1 | High while the sprite copy runs |
| dma_go | input | 1 | Start the sprite page copy |
| sys_rd | output | 1 | Copy read strobe to system memory |
| sys_addr | output | 16 | Copy read address |
| sys_rdata | input | 8 | System memory data, sampled at the end of the read cycle |
| vblank_start | input | 1 | Vertical blank begins (pulse) |
| vblank_end | input | 1 | Vertical blank ends (pulse) |
| obj0_hit | input | 1 | Sprite-zero overlap pulse from the renderer |
| nmi | output | 1 | NMI request level |
| ctrl_reg | output | 8 | Control byte |
| render_cfg | output | 8 | Render-configuration byte |
| scroll_x | output | 8 | Horizontal scroll |
| scroll_y | output | 8 | Vertical scroll |
| vram_addr | output | 14 | Video memory address (current pointer) |
| vram_rd | output | 1 | Video memory read strobe |
| vram_we | output | 1 | Video memory write strobe |
| vram_wdata | output | 8 | Video memory write data |
| vram_rdata | input | 8 | Video memory read data (combinational) |

## Verification
A wrong write toggle shows up on the very next scroll or pointer write, as swapped scroll values or a pointer byte landing in the wrong half. A wrong read buffer or pointer step shows up on the next video-data access, as a stale value or a wrong `vram_addr` in that same cycle. The bench sweeps pointer runs across the 16 KiB wrap with both step sizes and predicts every address and returned byte arithmetically. Errors in the sprite pointer or the copy are exposed by reading all 256 copied bytes back through the sprite-data port, compared against a computed memory pattern. Flag errors are caught one cycle after each strobe on `nmi` and on the status byte.

// File: rtl/vid_regif_pkg.sv
package vid_regif_pkg;

    typedef enum logic [2:0] {
        RG_CTRL = 3'd0,
        RG_CFG  = 3'd1,
        RG_STAT = 3'd2,
        RG_SCRL = 3'd3,
        RG_VPTR = 3'd4,
        RG_VDAT = 3'd5,
        RG_SPTR = 3'd6,
        RG_SDAT = 3'd7
    } reg_sel_e;

    localparam int CTRL_NMI_BIT  = 7;
    localparam int CTRL_STEP_BIT = 2;

endpackage

// File: rtl/vid_regif_oam.sv
module vid_regif_oam #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/vid_regif_dma.sv
module vid_regif_dma #(
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 8,
    parameter int DW     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [PAGE_W-1:0]       page,
    output logic                    busy,
    output logic                    sys_rd,
    output logic [PAGE_W+OFS_W-1:0] sys_addr,
    input  logic [DW-1:0]           sys_rdata,
    output logic                    oam_we,
    output logic [DW-1:0]           oam_wdata
);
    typedef struct packed {
        logic              busy;
        logic              wph;
        logic [OFS_W-1:0]  ofs;
        logic [PAGE_W-1:0] page;
        logic [DW-1:0]     data;
    } dma_st_t;

    dma_st_t q, d;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.wph  = 1'b0;
                d.ofs  = '0;
                d.page = page;
            end
        end else if (!q.wph) begin
            d.data = sys_rdata;
            d.wph  = 1'b1;
        end else begin
            d.wph = 1'b0;
            d.ofs = q.ofs + OFS_W'(1);
            if (q.ofs == '1) begin
                d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = q.busy;
    assign sys_rd    = q.busy & ~q.wph;
    assign sys_addr  = {q.page, q.ofs};
    assign oam_we    = q.busy & q.wph;
    assign oam_wdata = q.data;

endmodule

// File: rtl/vid_regif.sv
module vid_regif
    import vid_regif_pkg::*;
#(
    parameter int VA_W      = 14,
    parameter int OAM_AW    = 8,
    parameter int STEP_WIDE = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_sel,
    input  logic             cpu_we,
    input  logic [2:0]       cpu_addr,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    output logic             cpu_stall,
    input  logic             dma_go,
    output logic             sys_rd,
    output logic [15:0]      sys_addr,
    input  logic [7:0]       sys_rdata,
    input  logic             vblank_start,
    input  logic             vblank_end,
    input  logic             obj0_hit,
    output logic             nmi,
    output logic [7:0]       ctrl_reg,
    output logic [7:0]       render_cfg,
    output logic [7:0]       scroll_x,
    output logic [7:0]       scroll_y,
    output logic [VA_W-1:0]  vram_addr,
    output logic             vram_rd,
    output logic             vram_we,
    output logic [7:0]       vram_wdata,
    input  logic [7:0]       vram_rdata
);
    localparam int HI_W = VA_W - 8;

    typedef struct packed {
        logic [7:0]        ctrl;
        logic [7:0]        cfg;
        logic              vbl;
        logic              hit;
        logic              second;
        logic [7:0]        sx;
        logic [7:0]        sy;
        logic [VA_W-1:0]   va;
        logic [OAM_AW-1:0] oa;
        logic [7:0]        rbuf;
    } regs_t;

    regs_t q, d;

    reg_sel_e          rsel;
    logic              acc_rd, acc_wr;
    logic [VA_W-1:0]   step_v;
    logic              dma_we;
    logic [7:0]        dma_wd;
    logic              oam_we;
    logic [7:0]        oam_wd, oam_rd;
    logic [OAM_AW-1:0] oa_w;
    logic              hit_w;

    assign rsel   = reg_sel_e'(cpu_addr);
    assign acc_rd = cpu_sel & ~cpu_we & ~cpu_stall;
    assign acc_wr = cpu_sel & cpu_we & ~cpu_stall;
    assign step_v = q.ctrl[CTRL_STEP_BIT] ? VA_W'(STEP_WIDE) : VA_W'(1);
    assign oa_w   = q.oa;
    assign hit_w  = q.hit;

    always_comb begin
        d = q;
        d.hit = (q.hit | obj0_hit) & ~vblank_end;
        if (vblank_end) begin
            d.vbl = 1'b0;
        end
        if (acc_rd && rsel == RG_STAT) begin
            d.vbl    = 1'b0;
            d.second = 1'b0;
        end
        if (vblank_start) begin
            d.vbl = 1'b1;
        end
        if (acc_wr) begin
            case (rsel)
                RG_CTRL: d.ctrl = cpu_wdata;
                RG_CFG:  d.cfg  = cpu_wdata;
                RG_SCRL: begin
                    if (q.second) d.sy = cpu_wdata;
                    else          d.sx = cpu_wdata;
                    d.second = ~q.second;
                end
                RG_VPTR: begin
                    if (q.second) d.va[7:0]      = cpu_wdata;
                    else          d.va[VA_W-1:8] = cpu_wdata[HI_W-1:0];
                    d.second = ~q.second;
                end
                RG_VDAT: d.va = q.va + step_v;
                RG_SPTR: d.oa = cpu_wdata[OAM_AW-1:0];
                RG_SDAT: d.oa = q.oa + OAM_AW'(1);
                default: ;
            endcase
        end
        if (acc_rd) begin
            case (rsel)
                RG_VDAT: begin
                    d.rbuf = vram_rdata;
                    d.va   = q.va + step_v;
                end
                RG_SDAT: d.oa = q.oa + OAM_AW'(1);
                default: ;
            endcase
        end
        if (dma_we) begin
            d.oa = q.oa + OAM_AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (rsel)
            RG_STAT: cpu_rdata = {q.vbl, hit_w, 6'b0};
            RG_VDAT: cpu_rdata = q.rbuf;
            RG_SDAT: cpu_rdata = oam_rd;
            default: cpu_rdata = 8'h00;
        endcase
    end

    assign oam_we = (acc_wr && rsel == RG_SDAT) || dma_we;
    assign oam_wd = dma_we ? dma_wd : cpu_wdata;

    vid_regif_oam #(
        .AW (OAM_AW),
        .DW (8)
    ) u_oam (
        .clk   (clk),
        .we    (oam_we),
        .addr  (oa_w),
        .wdata (oam_wd),
        .rdata (oam_rd)
    );

    vid_regif_dma #(
        .PAGE_W (8),
        .OFS_W  (OAM_AW),
        .DW     (8)
    ) u_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (dma_go),
        .page      (cpu_wdata),
        .busy      (cpu_stall),
        .sys_rd    (sys_rd),
        .sys_addr  (sys_addr),
        .sys_rdata (sys_rdata),
        .oam_we    (dma_we),
        .oam_wdata (dma_wd)
    );

    assign nmi        = q.ctrl[CTRL_NMI_BIT] & q.vbl;
    assign ctrl_reg   = q.ctrl;
    assign render_cfg = q.cfg;
    assign scroll_x   = q.sx;
    assign scroll_y   = q.sy;
    assign vram_addr  = q.va;
    assign vram_rd    = acc_rd && rsel == RG_VDAT;
    assign vram_we    = acc_wr && rsel == RG_VDAT;
    assign vram_wdata = cpu_wdata;

endmodule

// File: rtl/vid_regif_chk.sv
module vid_regif_chk #(
    parameter int VA_W      = 14,
    parameter int OAM_AW    = 8,
    parameter int STEP_WIDE = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_sel,
    input logic              cpu_we,
    input logic [2:0]        cpu_addr,
    input logic              stall,
    input logic              dma_go,
    input logic              vblank_start,
    input logic              vblank_end,
    input logic              nmi_en,
    input logic              step_big,
    input logic              nmi,
    input logic [VA_W-1:0]   vram_addr,
    input logic              vram_rd,
    input logic              vram_we,
    input logic [OAM_AW-1:0] oam_addr,
    input logic              hit
);
    localparam int DMA_CYC = 2 * (1 << OAM_AW);
    localparam int CW      = $clog2(DMA_CYC) + 1;

    logic [CW-1:0] stall_cnt;
    logic          ctrl_wr;
    logic          sdat_acc;

    assign ctrl_wr  = cpu_sel && cpu_we && cpu_addr == 3'd0 && !stall;
    assign sdat_acc = cpu_sel && cpu_addr == 3'd7 && !stall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stall_cnt <= '0;
        end else if (stall) begin
            stall_cnt <= stall_cnt + CW'(1);
        end else begin
            stall_cnt <= '0;
        end
    end

    AST_VPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_rd || vram_we) |=> vram_addr == VA_W'($past(vram_addr)
            + ($past(step_big) ? VA_W'(STEP_WIDE) : VA_W'(1)))); // R3

    AST_NMI_AT_VBL: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank_start && !ctrl_wr) |=> (nmi == nmi_en)); // R7

    AST_HIT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_end |=> !hit); // R8

    AST_SPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sdat_acc |=> oam_addr == OAM_AW'($past(oam_addr) + OAM_AW'(1))); // R10

    AST_DMA_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_go && !stall) |=> stall); // R11

    AST_DMA_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && stall_cnt != '0) |-> stall_cnt == CW'(DMA_CYC)); // R11

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!vram_rd && !vram_we)); // R11

endmodule

bind vid_regif vid_regif_chk #(
    .VA_W      (VA_W),
    .OAM_AW    (OAM_AW),
    .STEP_WIDE (STEP_WIDE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_sel      (cpu_sel),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .stall        (cpu_stall),
    .dma_go       (dma_go),
    .vblank_start (vblank_start),
    .vblank_end   (vblank_end),
    .nmi_en       (ctrl_reg[7]),
    .step_big     (ctrl_reg[2]),
    .nmi          (nmi),
    .vram_addr    (vram_addr),
    .vram_rd      (vram_rd),
    .vram_we      (vram_we),
    .oam_addr     (oa_w),
    .hit          (hit_w)
);

// File: tb/test_vid_regif.sv
`timescale 1ns/1ps
module test_vid_regif;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [2:0]  cpu_addr = 3'd0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic        cpu_stall, dma_go = 1'b0, sys_rd;
    logic [15:0] sys_addr;
    logic [7:0]  sys_rdata;
    logic        vblank_start = 1'b0, vblank_end = 1'b0, obj0_hit = 1'b0;
    logic        nmi;
    logic [7:0]  ctrl_reg, render_cfg, scroll_x, scroll_y;
    logic [13:0] vram_addr;
    logic        vram_rd, vram_we;
    logic [7:0]  vram_wdata, vram_rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic        l_vwe, l_vrd;
    logic [13:0] l_vaddr;
    logic [7:0]  l_vwd;

    always #2 clk = ~clk;

    function automatic logic [7:0] vmod(input logic [13:0] a);
        return a[7:0] ^ {2'b00, a[13:8]} ^ 8'hA5;
    endfunction

    function automatic logic [7:0] smod(input logic [15:0] a);
        return 8'(a[7:0] * 8'd5 + a[15:8]);
    endfunction

    assign vram_rdata = vmod(vram_addr);
    assign sys_rdata  = smod(sys_addr);

    vid_regif i_vid_regif (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .dma_go(dma_go), .sys_rd(sys_rd),
        .sys_addr(sys_addr), .sys_rdata(sys_rdata),
        .vblank_start(vblank_start), .vblank_end(vblank_end),
        .obj0_hit(obj0_hit), .nmi(nmi), .ctrl_reg(ctrl_reg),
        .render_cfg(render_cfg), .scroll_x(scroll_x), .scroll_y(scroll_y),
        .vram_addr(vram_addr), .vram_rd(vram_rd), .vram_we(vram_we),
        .vram_wdata(vram_wdata), .vram_rdata(vram_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic bus(input logic w, input logic [2:0] a, input logic [7:0] dat,
                       output logic [7:0] r);
        cpu_sel = 1'b1; cpu_we = w; cpu_addr = a; cpu_wdata = dat;
        #1;
        r = cpu_rdata; l_vwe = vram_we; l_vrd = vram_rd;
        l_vaddr = vram_addr; l_vwd = vram_wdata;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic pulse(input int which);
        if (which == 0) vblank_start = 1'b1;
        if (which == 1) vblank_end = 1'b1;
        if (which == 2) obj0_hit = 1'b1;
        @(negedge clk);
        vblank_start = 1'b0; vblank_end = 1'b0; obj0_hit = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog (all requirements) act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  r;
        logic [13:0] ea;
        logic [7:0]  ebuf;
        int          cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ctrl", ctrl_reg, 0);
        check("R1 cfg", render_cfg, 0);
        check("R1 scroll", {scroll_x, scroll_y}, 0);
        check("R1 vptr", vram_addr, 0);
        check("R1 nmi/stall", {nmi, cpu_stall}, 0);
        bus(0, 3'd2, 0, r);
        check("R1 status", r, 0);

        // R2 control and render-config
        bus(1, 3'd0, 8'h80, r);
        bus(1, 3'd1, 8'h1E, r);
        check("R2 ctrl", ctrl_reg, 8'h80);
        check("R2 cfg", render_cfg, 8'h1E);

        // R4 pointer high then low
        bus(0, 3'd2, 0, r);
        bus(1, 3'd4, 8'hFA, r);
        bus(1, 3'd4, 8'h55, r);
        check("R4 vptr", vram_addr, 14'h3A55);

        // R3 step sweep with wrap, both step sizes
        for (int st = 0; st < 2; st++) begin
            bus(1, 3'd0, (st != 0) ? 8'h04 : 8'h00, r);
            bus(0, 3'd2, 0, r);
            bus(1, 3'd4, 8'h3F, r);
            bus(1, 3'd4, 8'hE0, r);
            ea = 14'h3FE0;
            for (int k = 0; k < 40; k++) begin
                bus(1, 3'd5, 8'(k + st * 64), r);
                check("R3 we", l_vwe, 1);
                check("R3 addr", l_vaddr, ea);
                check("R3 wdata", l_vwd, 8'(k + st * 64));
                ea = 14'(ea + ((st != 0) ? 32 : 1));
            end
            check("R3 final vptr", vram_addr, ea);
        end

        // R9 buffered reads
        bus(1, 3'd0, 8'h00, r);
        bus(0, 3'd2, 0, r);
        bus(1, 3'd4, 8'h12, r);
        bus(1, 3'd4, 8'h34, r);
        ebuf = 8'h00;
        for (int k = 0; k < 8; k++) begin
            bus(0, 3'd5, 0, r);
            check("R9 rdata", r, ebuf);
            check("R9 rd strobe", l_vrd, 1);
            check("R9 fetch addr", l_vaddr, 14'(14'h1234 + k));
            ebuf = vmod(14'(14'h1234 + k));
        end

        // R5 scroll pair and shared toggle
        bus(0, 3'd2, 0, r);
        bus(1, 3'd3, 8'h12, r);
        bus(1, 3'd3, 8'h34, r);
        check("R5 x", scroll_x, 8'h12);
        check("R5 y", scroll_y, 8'h34);
        bus(1, 3'd3, 8'h77, r);
        bus(1, 3'd4, 8'h99, r);
        check("R5 shared toggle low byte", vram_addr, 14'h1299);
        check("R5 x second", scroll_x, 8'h77);

        // R6 status read resets toggle
        bus(1, 3'd3, 8'h5A, r);
        bus(0, 3'd2, 0, r);
        bus(1, 3'd3, 8'h6B, r);
        check("R6 toggle reset x", scroll_x, 8'h6B);
        check("R6 y kept", scroll_y, 8'h34);

        // R7 vblank flag and nmi
        bus(1, 3'd0, 8'h80, r);
        pulse(0);
        check("R7 nmi on", nmi, 1);
        bus(0, 3'd2, 0, r);
        check("R6 status vbl", r, 8'h80);
        check("R7 nmi cleared", nmi, 0);
        bus(0, 3'd2, 0, r);
        check("R6 status cleared", r, 8'h00);
        vblank_start = 1'b1;
        bus(0, 3'd2, 0, r);
        vblank_start = 1'b0;
        check("R7 race old value", r, 8'h00);
        check("R7 race set wins", nmi, 1);
        bus(1, 3'd0, 8'h00, r);
        check("R7 nmi masked", nmi, 0);
        bus(0, 3'd2, 0, r);
        check("R7 flag still set", r, 8'h80);
        pulse(0);
        pulse(1);
        bus(0, 3'd2, 0, r);
        check("R7 end clears", r, 8'h00);

        // R8 sprite-zero flag
        pulse(2);
        bus(0, 3'd2, 0, r);
        check("R8 hit set", r, 8'h40);
        bus(0, 3'd2, 0, r);
        check("R8 hit kept", r, 8'h40);
        pulse(1);
        bus(0, 3'd2, 0, r);
        check("R8 hit cleared", r, 8'h00);

        // R10 sprite port with wrap
        bus(1, 3'd6, 8'hFE, r);
        bus(1, 3'd7, 8'h11, r);
        bus(1, 3'd7, 8'h22, r);
        bus(1, 3'd7, 8'h33, r);
        bus(1, 3'd6, 8'hFE, r);
        bus(0, 3'd7, 0, r);
        check("R10 read FE", r, 8'h11);
        bus(0, 3'd7, 0, r);
        check("R10 read FF", r, 8'h22);
        bus(0, 3'd7, 0, r);
        check("R10 read 00 wrap", r, 8'h33);

        // R11 page copy
        bus(1, 3'd6, 8'h10, r);
        dma_go = 1'b1; cpu_wdata = 8'h23;
        @(negedge clk);
        dma_go = 1'b0;
        cnt = 0;
        while (cpu_stall && cnt < 2000) begin
            if (cnt == 3) begin
                cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = 3'd0; cpu_wdata = 8'hFF;
            end else begin
                cpu_sel = 1'b0; cpu_we = 1'b0;
            end
            cnt++;
            @(negedge clk);
        end
        cpu_sel = 1'b0; cpu_we = 1'b0;
        check("R11 stall length", cnt, 512);
        check("R11 access ignored", ctrl_reg, 8'h00);
        for (int i = 0; i < 256; i++) begin
            bus(0, 3'd7, 0, r);
            check("R11 copied byte", r, smod(16'(16'h2300 + i)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule